// File: doc/BRIEF.md
# Vectored Interrupt Controller with Spurious Vector Handling

This block collects up to `NUM_SRC` interrupt inputs and presents them to a processor on two active-low request lines. One is a fast line that only source 0 drives. The other is a normal line that every other source drives. Each source can be set to edge or level sensitivity, and each has an enable bit, a priority and a handler address. When software reads the vector register, the controller returns the handler address of the highest-priority source that is pending and enabled, and marks that source as in service. An end-of-interrupt write releases the in-service state.

When a vector read finds nothing that qualifies, the read returns a software-set spurious address. This covers a level pulse that has already gone away and a source that was disabled just before the read. A global mask bit forces both request lines inactive. While the mask is set, a separate wakeup output still reports that something enabled is pending, so a processor in idle mode can still be woken.

Software reaches all registers through a simple synchronous word bus. Read data is registered and appears in the cycle after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset, irqN and fiqN are 1 and wakeup is 0. The enable status reads 0, and a vector read returns the reset spurious value 0.
- R2: Source mode word i is at address i, with priority in bits [2:0] and bit 4 set to 1 for edge or 0 for level. The handler word for source i is at address NUM_SRC+i. A vector read at address 2*NUM_SRC+0 returns the handler of the pending enabled source with the largest priority. Ties go to the lowest index.
- R3: The spurious register is at 2*NUM_SRC+1. A vector read with no qualifying source returns its contents, including after a level source has pulsed and dropped. An end-of-interrupt write after such a read has no effect.
- R4: A source cleared from the enable mask after it asserts, but before the vector read, yields the spurious value.
- R5: fiqN is 0 exactly when source 0 is pending and enabled and the mask is clear. Sources 1 and up drive only irqN.
- R6: A non-spurious vector read records that source's priority as the in-service level. irqN then asserts only for sources whose priority exceeds that level, and a vector read ignores sources at or below it. A write of any value to address 2*NUM_SRC+6 clears the in-service state.
- R7: Bit 1 of the debug control word at 2*NUM_SRC+7 forces irqN and fiqN to 1 while it is set.
- R8: wakeup is 1 whenever any enabled source is pending, whatever the mask holds.
- R9: An edge source becomes pending on a rising input and stays pending after the input falls. A vector read that selects it clears the flag. A level source is pending only while its input is 1.
- R10: Enable bits are set by writing ones to 2*NUM_SRC+2 and cleared by writing ones to 2*NUM_SRC+3. The enable mask reads at 2*NUM_SRC+4. Raw pending, before the enable mask is applied, reads at 2*NUM_SRC+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Word address |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| srcIn | input | NUM_SRC | Interrupt source inputs |
| irqN | output | 1 | Normal interrupt request, active low |
| fiqN | output | 1 | Fast interrupt request, active low |
| wakeup | output | 1 | Idle wakeup, active high |

## Verification
The arbitration is tried with several patterns:
- Two sources at different priorities, which shows that priority wins over index.
- Two sources at equal priority, which shows that the lowest index wins.
- Several sources under a restricted enable mask, which shows that the mask gates selection.
- Source 0 alone and together with another source, which separates the fast line from the normal line.

The spurious path is tried in three ways: with no inputs, with inputs present but disabled, and with a one-cycle level pulse. This shows that the vector is decided at the moment of the read and not earlier.

Directed sequences check the other behaviours:
- Nesting above and below an in-service level.
- Edge latching and clearing.
- The mask silencing both lines while wakeup stays high.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int IDX_W = 8;
  localparam int MODE_EDGE_BIT = 4;
  localparam int DBG_MASK_BIT = 1;
  localparam int OFS_IVR = 0;
  localparam int OFS_SPU = 1;
  localparam int OFS_ENSET = 2;
  localparam int OFS_ENCLR = 3;
  localparam int OFS_ENSTAT = 4;
  localparam int OFS_PEND = 5;
  localparam int OFS_EOI = 6;
  localparam int OFS_DBG = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_VEC, SEL_IVR, SEL_SPU, SEL_ENSTAT, SEL_PEND, SEL_DBG
  } rdSel_e;

  typedef struct packed {
    logic       wrMode;
    logic       wrVec;
    logic       wrSpu;
    logic       enSet;
    logic       enClr;
    logic       eoi;
    logic       wrDbg;
    logic       rdVector;
    rdSel_e     rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'(2 * NUM_SRC);

  logic [ADDR_W-1:0] ofs;

  always_comb begin
    strobe = '0;
    ofs    = busAddr - CTL_BASE;
    if (busAddr < VEC_BASE) begin
      strobe.idx    = IDX_W'(busAddr);
      strobe.wrMode = busWrite;
      if (busRead) strobe.rdSel = SEL_MODE;
    end else if (busAddr < CTL_BASE) begin
      strobe.idx   = IDX_W'(busAddr - VEC_BASE);
      strobe.wrVec = busWrite;
      if (busRead) strobe.rdSel = SEL_VEC;
    end else begin
      case (ofs)
        ADDR_W'(OFS_IVR): begin
          strobe.rdVector = busRead;
          if (busRead) strobe.rdSel = SEL_IVR;
        end
        ADDR_W'(OFS_SPU): begin
          strobe.wrSpu = busWrite;
          if (busRead) strobe.rdSel = SEL_SPU;
        end
        ADDR_W'(OFS_ENSET):  strobe.enSet = busWrite;
        ADDR_W'(OFS_ENCLR):  strobe.enClr = busWrite;
        ADDR_W'(OFS_ENSTAT): if (busRead) strobe.rdSel = SEL_ENSTAT;
        ADDR_W'(OFS_PEND):   if (busRead) strobe.rdSel = SEL_PEND;
        ADDR_W'(OFS_EOI):    strobe.eoi = busWrite;
        ADDR_W'(OFS_DBG): begin
          strobe.wrDbg = busWrite;
          if (busRead) strobe.rdSel = SEL_DBG;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqN,
  output logic               fiqN,
  output logic               wakeup,
  output logic               maskObs,
  output logic               inServiceObs,
  output logic [DATA_W-1:0]  spuObs
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [PRIO_W-1:0] prioArr [NUM_SRC];
  logic              edgeArr [NUM_SRC];
  logic [DATA_W-1:0] vecArr  [NUM_SRC];
  logic [NUM_SRC-1:0] pending, pendEn, cand;
  logic [NUM_SRC-1:0] srcPrev, enReg;
  logic [DATA_W-1:0]  spuReg;
  logic               inService, dbgMask;
  logic [PRIO_W-1:0]  isPrio;
  logic               found;
  logic [SRC_W-1:0]   bestIdx;
  logic [PRIO_W-1:0]  bestPrio;
  logic               takeVec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [PRIO_W-1:0] prio;
    logic              isEdge;
    logic [DATA_W-1:0] vec;
    logic              flag;
    logic              hit;
    assign hit = (strobe.idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prio   <= '0;
        isEdge <= 1'b0;
        vec    <= '0;
        flag   <= 1'b0;
      end else begin
        if (strobe.wrMode && hit) begin
          prio   <= busWdata[PRIO_W-1:0];
          isEdge <= busWdata[MODE_EDGE_BIT];
        end
        if (strobe.wrVec && hit) vec <= busWdata;
        if (isEdge && srcIn[g] && !srcPrev[g]) flag <= 1'b1;
        else if (!isEdge || (takeVec && bestIdx == SRC_W'(g))) flag <= 1'b0;
      end
    end
    assign prioArr[g] = prio;
    assign edgeArr[g] = isEdge;
    assign vecArr[g]  = vec;
    assign pending[g] = isEdge ? flag : srcIn[g];
    assign pendEn[g]  = pending[g] & enReg[g];
    assign cand[g]    = pendEn[g] && (!inService || prio > isPrio);
  end

  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || prioArr[i] > bestPrio)) begin
        found    = 1'b1;
        bestIdx  = SRC_W'(i);
        bestPrio = prioArr[i];
      end
    end
  end

  assign takeVec = strobe.rdVector && found;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev   <= '0;
      enReg     <= '0;
      spuReg    <= '0;
      inService <= 1'b0;
      isPrio    <= '0;
      dbgMask   <= 1'b0;
    end else begin
      srcPrev <= srcIn;
      if (strobe.enSet) enReg <= enReg | busWdata[NUM_SRC-1:0];
      else if (strobe.enClr) enReg <= enReg & ~busWdata[NUM_SRC-1:0];
      if (strobe.wrSpu) spuReg <= busWdata;
      if (strobe.wrDbg) dbgMask <= busWdata[DBG_MASK_BIT];
      if (takeVec) begin
        inService <= 1'b1;
        isPrio    <= bestPrio;
      end else if (strobe.eoi) begin
        inService <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else begin
      case (strobe.rdSel)
        SEL_MODE: begin
          busRdata <= '0;
          busRdata[PRIO_W-1:0]    <= prioArr[strobe.idx[SRC_W-1:0]];
          busRdata[MODE_EDGE_BIT] <= edgeArr[strobe.idx[SRC_W-1:0]];
        end
        SEL_VEC:    busRdata <= vecArr[strobe.idx[SRC_W-1:0]];
        SEL_IVR:    busRdata <= found ? vecArr[bestIdx] : spuReg;
        SEL_SPU:    busRdata <= spuReg;
        SEL_ENSTAT: busRdata <= DATA_W'(enReg);
        SEL_PEND:   busRdata <= DATA_W'(pending);
        SEL_DBG: begin
          busRdata <= '0;
          busRdata[DBG_MASK_BIT] <= dbgMask;
        end
        default: ;
      endcase
    end
  end

  logic irqAny;
  assign irqAny = |cand[NUM_SRC-1:1];
  assign irqN   = !irqAny || dbgMask;
  assign fiqN   = !pendEn[0] || dbgMask;
  assign wakeup = |pendEn;

  assign maskObs      = dbgMask;
  assign inServiceObs = inService;
  assign spuObs       = spuReg;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrite,
  input  logic               busRead,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqN,
  output logic               fiqN,
  output logic               wakeup
);
  strobe_t           strobe;
  logic              maskObs;
  logic              inServiceObs;
  logic [DATA_W-1:0] spuObs;

  vic_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) ctrl_i (
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead), .strobe(strobe)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .srcIn(srcIn), .irqN(irqN), .fiqN(fiqN),
    .wakeup(wakeup), .maskObs(maskObs), .inServiceObs(inServiceObs),
    .spuObs(spuObs)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busRead,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqN,
  input logic              fiqN,
  input logic              wakeup,
  input logic              maskObs,
  input logic              inServiceObs,
  input logic [DATA_W-1:0] spuObs
);
  localparam logic [ADDR_W-1:0] IVR_ADDR = ADDR_W'(2 * NUM_SRC + OFS_IVR);
  localparam logic [ADDR_W-1:0] EOI_ADDR = ADDR_W'(2 * NUM_SRC + OFS_EOI);

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    maskObs |-> (irqN && fiqN)); // R7
  AST_FIQ_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    !fiqN |-> wakeup); // R8
  AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> wakeup); // R8
  AST_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == IVR_ADDR && !wakeup) |=> (busRdata == $past(spuObs))); // R3
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == EOI_ADDR) |=> !inServiceObs); // R6
  AST_VEC_INSERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == IVR_ADDR && wakeup && !inServiceObs) |=> inServiceObs); // R2
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
  .busRdata(busRdata), .irqN(irqN), .fiqN(fiqN), .wakeup(wakeup), .maskObs(maskObs),
  .inServiceObs(inServiceObs), .spuObs(spuObs)
);

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
  localparam int N = 32;
  localparam logic [7:0] A_IVR = 8'h40, A_SPU = 8'h41, A_ENSET = 8'h42, A_ENCLR = 8'h43;
  localparam logic [7:0] A_ENSTAT = 8'h44, A_PEND = 8'h45, A_EOI = 8'h46, A_DBG = 8'h47;
  localparam logic [31:0] SPU = 32'hDEAD_0000;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [31:0] vec;
    logic        irqN;
    logic        fiqN;
    logic        wake;
  } row_t;

  // priority of source i is (3*i) % 8, all level sensitive, handler 0x1000+i
  localparam row_t ROWS [8] = '{
    '{32'h0000_0006, 32'hFFFF_FFFF, 32'h1002, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0022, 32'hFFFF_FFFF, 32'h1005, 1'b0, 1'b1, 1'b1},
    '{32'h0000_2020, 32'hFFFF_FFFF, 32'h1005, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0006, 32'h0000_0002, 32'h1001, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, SPU,      1'b1, 1'b1, 1'b0},
    '{32'h0000_0006, 32'h0000_0000, SPU,      1'b1, 1'b1, 1'b0},
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h1000, 1'b1, 1'b0, 1'b1},
    '{32'h0000_0101, 32'hFFFF_FFFF, 32'h1000, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] srcIn = '0;
  logic        irqN, fiqN, wakeup;
  int nChecks = 0, nErr = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  vic_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqN(irqN),
    .fiqN(fiqN), .wakeup(wakeup)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    d = busRdata;
  endtask

  task automatic setSrc(input logic [N-1:0] s);
    @(negedge clk);
    srcIn = s;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nErr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqN", 32'(irqN), 32'd1);
    check("R1 fiqN", 32'(fiqN), 32'd1);
    check("R1 wakeup", 32'(wakeup), 32'd0);
    busRd(A_ENSTAT, rd); check("R1 enable", rd, 32'd0);
    busRd(A_IVR, rd);    check("R1 spurious", rd, 32'd0);
    busWr(A_EOI, 32'd0);

    for (int i = 0; i < N; i++) begin
      busWr(8'(i), 32'((3 * i) % 8));
      busWr(8'(N + i), 32'h1000 + 32'(i));
    end
    busWr(A_SPU, SPU);
    busRd(A_SPU, rd); check("R3 spurious readback", rd, SPU);

    // R2 R3 R4 R5 R8 table walk
    for (int r = 0; r < 8; r++) begin
      busWr(A_ENCLR, 32'hFFFF_FFFF);
      busWr(A_ENSET, ROWS[r].en);
      setSrc(ROWS[r].src);
      check($sformatf("R5 irqN row%0d", r), 32'(irqN), 32'(ROWS[r].irqN));
      check($sformatf("R5 fiqN row%0d", r), 32'(fiqN), 32'(ROWS[r].fiqN));
      check($sformatf("R8 wakeup row%0d", r), 32'(wakeup), 32'(ROWS[r].wake));
      busRd(A_IVR, rd);
      check($sformatf("R2 vector row%0d", r), rd, ROWS[r].vec);
      busWr(A_EOI, 32'd0);
      setSrc('0);
    end
    busWr(A_ENSET, 32'hFFFF_FFFF);
    busRd(A_ENSTAT, rd); check("R10 enable status", rd, 32'hFFFF_FFFF);

    // R7 mask with R8 wakeup
    setSrc(32'h5);
    busWr(A_DBG, 32'h2);
    check("R7 irqN masked", 32'(irqN), 32'd1);
    check("R7 fiqN masked", 32'(fiqN), 32'd1);
    check("R8 wakeup under mask", 32'(wakeup), 32'd1);
    busWr(A_DBG, 32'h0);
    check("R7 irqN unmasked", 32'(irqN), 32'd0);
    check("R7 fiqN unmasked", 32'(fiqN), 32'd0);
    setSrc('0);

    // R3 brief level pulse
    setSrc(32'h8);
    setSrc('0);
    busRd(A_IVR, rd); check("R3 pulse gone", rd, SPU);
    busWr(A_EOI, 32'hFFFF_FFFF);
    check("R3 eoi after spurious irqN", 32'(irqN), 32'd1);

    // R4 disable in window
    setSrc(32'h40);
    busWr(A_ENCLR, 32'h40);
    busRd(A_IVR, rd); check("R4 disabled source", rd, SPU);
    check("R4 irqN", 32'(irqN), 32'd1);
    busWr(A_ENSET, 32'h40);
    setSrc('0);

    // R9 edge source 4, prio 4
    busWr(8'd4, 32'h14);
    setSrc(32'h10);
    setSrc('0);
    check("R9 edge held irqN", 32'(irqN), 32'd0);
    busRd(A_PEND, rd); check("R10 pending edge", rd, 32'h10);
    busRd(A_IVR, rd);  check("R9 edge vector", rd, 32'h1004);
    busRd(A_PEND, rd); check("R9 edge cleared", rd, 32'h0);
    busWr(A_EOI, 32'd0);
    check("R9 irqN idle", 32'(irqN), 32'd1);

    // R6 in-service level
    setSrc(32'h2);
    busRd(A_IVR, rd); check("R6 first vector", rd, 32'h1001);
    check("R6 same level irqN", 32'(irqN), 32'd1);
    setSrc(32'hA);
    check("R6 lower level irqN", 32'(irqN), 32'd1);
    busRd(A_IVR, rd); check("R6 lower ignored", rd, SPU);
    setSrc(32'hE);
    check("R6 higher level irqN", 32'(irqN), 32'd0);
    busWr(A_EOI, 32'h1234);
    busRd(A_IVR, rd); check("R6 after eoi", rd, 32'h1002);
    busWr(A_EOI, 32'd0);
    setSrc('0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule